// File: doc/BRIEF.md
# Timeslot-Gated PRBS Bit Error Checker

This block watches a serial TDM receive stream and counts bit errors against a 2^15-1 pseudo-random reference. Checking happens only in timeslots that software has switched on in a per-timeslot enable register. The enabled timeslots are treated as one unbroken sequence. Disabled timeslots are skipped entirely, and the sequence picks up in the first enabled timeslot of the next frame where the last enabled timeslot of the previous frame left off.

A local reference generator first locks onto the incoming pattern by loading received bits. Once it has locked, it runs freely and each mismatching bit raises a 16-bit saturating error counter. Software reads the counter and the enable bits through a small register port and clears the counter by writing any value to it. Bits arrive one per `clk` cycle while `bit_en` is high, and `frame_pulse` marks the first bit of each frame.

Top module: `tsprbs_checker`

## Requirements
- R1: After reset, the error counter (address 1) reads 0 and the enable register (address 0) reads 0.
- R2: A write to address 0 loads the enable register, where bit i enables timeslot i; reading address 0 returns that value, zero-extended.
- R3: Disabled timeslots neither advance the reference nor update the lock state. The enabled timeslots form one continuous sequence that carries on from frame to frame.
- R4: The reference follows b[n] = b[n-14] XOR b[n-15] (polynomial x^15 + x^14 + 1). An error-free stream in the enabled timeslots leaves the counter at 0.
- R5: Once locked, every received bit in an enabled timeslot that differs from the reference adds exactly one to the counter.
- R6: Data in disabled timeslots never changes the error counter.
- R7: While unlocked, the reference loads the received bits. Lock is declared after 15 consecutive bits match the prediction, and no error is counted before lock.
- R8: The counter holds at 65535 instead of wrapping. Address 1 returns the count in bits 15:0, with the upper bits zero.
- R9: A write of any value to address 1 clears the counter, and this takes precedence over an error in the same cycle. Such a write leaves the enable register unchanged.
- R10: A frame is 32 timeslots of 8 bits, sent MSB first. A bit strobed together with `frame_pulse` is bit 0 (the MSB) of timeslot 0, even if it comes before the previous frame is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Received bit is valid this cycle |
| frame_pulse | input | 1 | This bit is the first bit of a frame |
| rx_bit | input | 1 | Serial receive data |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write address: 0 enable, 1 error counter |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 1 | Read address: 0 enable, 1 error counter |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |

## Verification
The assertions take several things for granted about the inputs. `frame_pulse` only has meaning on cycles where `bit_en` is high. The data in the enabled timeslots is a valid continuation of the x^15 + x^14 + 1 sequence, so a lock declared after 15 matches is a true lock. Register writes arrive at any time. The stimulus respects these assumptions: it raises `frame_pulse` only alongside a strobed bit, it derives every enabled-timeslot bit from a bench-side recurrence, and it flips bits only after at least 30 sequence bits have been sent since the reference started on the stream, which is after lock is certain. Disabled timeslots carry an unrelated pattern so that any leakage into the reference or the counter would show.

// File: rtl/tsprbs_pkg.sv
package tsprbs_pkg;
  localparam int PRBS_LEN = 15;
  localparam int TAP_A    = 14;  // b[n-15]
  localparam int TAP_B    = 13;  // b[n-14]

  typedef enum logic {
    RA_ENABLE = 1'b0,
    RA_ERRCNT = 1'b1
  } reg_addr_e;

  // Next reference bit from the history register (oldest bit at the top).
  function automatic logic prbs_next(input logic [PRBS_LEN-1:0] hist);
    return hist[TAP_A] ^ hist[TAP_B];
  endfunction
endpackage

// File: rtl/tsprbs_slot_tracker.sv
module tsprbs_slot_tracker #(
  parameter int NSLOTS    = 32,
  parameter int SLOT_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_pulse,
  input  logic [NSLOTS-1:0] en_mask,
  output logic              active
);
  localparam int FRAME_BITS = NSLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_W     = $clog2(NSLOTS);

  logic [POS_W-1:0]  pos_q, cur_pos;
  logic [SLOT_W-1:0] cur_slot;
  logic              frame_start;

  assign frame_start = bit_en && frame_pulse;
  assign cur_pos     = frame_pulse ? '0 : pos_q;
  assign cur_slot    = SLOT_W'(cur_pos / POS_W'(SLOT_BITS));
  assign active      = bit_en && en_mask[cur_slot];

  always_ff @(posedge clk) begin
    if (!rst_n)
      pos_q <= '0;
    else if (bit_en)
      pos_q <= (cur_pos == POS_W'(FRAME_BITS - 1)) ? '0 : cur_pos + 1'b1;
  end

  // R10: a pulsed bit is position 0, so the next bit is position 1
  a_r10_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pos_q == POS_W'(1));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_q));
endmodule

// File: rtl/tsprbs_ref_gen.sv
module tsprbs_ref_gen
  import tsprbs_pkg::*;
#(
  parameter int LOCK_RUN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rx_bit,
  output logic err_pulse,
  output logic locked
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [PRBS_LEN-1:0] hist_q;
  logic [RUN_W-1:0]    run_q;
  logic                locked_q, pred, match, run_done;

  assign pred      = prbs_next(hist_q);
  assign match     = (rx_bit == pred);
  assign run_done  = (run_q == RUN_W'(LOCK_RUN - 1));
  assign err_pulse = active && locked_q && !match;
  assign locked    = locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q   <= '0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (active) begin
      if (!locked_q) begin
        hist_q <= {hist_q[PRBS_LEN-2:0], rx_bit};
        if (match) begin
          run_q <= run_q + 1'b1;
          if (run_done) locked_q <= 1'b1;
        end else begin
          run_q <= '0;
        end
      end else begin
        hist_q <= {hist_q[PRBS_LEN-2:0], pred};
      end
    end
  end

  // R3: skipped timeslots leave the reference untouched
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(hist_q) && $stable(locked_q));

  // R7: lock only follows a matching active bit
  a_r7_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(active && match));

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
endmodule

// File: rtl/tsprbs_err_counter.sv
module tsprbs_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= sat_add(cnt_q);
  end

  // R8: never wraps past the ceiling
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  // R9: a clear always lands
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

  // R5: one error, one step
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R6: no error, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/tsprbs_checker.sv
module tsprbs_checker
  import tsprbs_pkg::*;
#(
  parameter int NSLOTS    = 32,
  parameter int SLOT_BITS = 8,
  parameter int CNT_W     = 16,
  parameter int DW        = 32,
  parameter int LOCK_RUN  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          frame_pulse,
  input  logic          rx_bit,
  input  logic          reg_we,
  input  logic          reg_waddr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_raddr,
  output logic [DW-1:0] reg_rdata
);
  logic [NSLOTS-1:0] en_mask_q;
  logic [CNT_W-1:0]  err_count;
  logic              slot_active, err_pulse, ref_locked;
  logic              wr_enable, wr_errcnt;

  assign wr_enable = reg_we && (reg_addr_e'(reg_waddr) == RA_ENABLE);
  assign wr_errcnt = reg_we && (reg_addr_e'(reg_waddr) == RA_ERRCNT);

  always_ff @(posedge clk) begin
    if (!rst_n)         en_mask_q <= '0;
    else if (wr_enable) en_mask_q <= reg_wdata[NSLOTS-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr_e'(reg_raddr) == RA_ENABLE) reg_rdata[NSLOTS-1:0] = en_mask_q;
    else                                     reg_rdata[CNT_W-1:0]  = err_count;
  end

  tsprbs_slot_tracker #(.NSLOTS(NSLOTS), .SLOT_BITS(SLOT_BITS)) u_track (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
    .en_mask(en_mask_q), .active(slot_active));

  tsprbs_ref_gen #(.LOCK_RUN(LOCK_RUN)) u_ref (
    .clk(clk), .rst_n(rst_n), .active(slot_active), .rx_bit(rx_bit),
    .err_pulse(err_pulse), .locked(ref_locked));

  tsprbs_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wr_errcnt), .inc(err_pulse),
    .count(err_count));

  // R2: the enable register takes the written value
  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> en_mask_q == $past(reg_wdata[NSLOTS-1:0]));

  // R9: clearing the counter leaves the enables alone
  a_r9_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(en_mask_q));

  // R7: errors only counted in a locked state
  a_r7_no_err_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_locked |=> $stable(err_count) || err_count == '0);
endmodule

// File: tb/tsprbs_checker_bench.sv
module tsprbs_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, frame_pulse = 1'b0, rx_bit = 1'b0;
  logic        reg_we = 1'b0, reg_waddr = 1'b0, reg_raddr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;  // 125 MHz

  tsprbs_checker u_tsprbs_checker (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_pulse(frame_pulse),
    .rx_bit(rx_bit), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  typedef struct {
    logic        addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];
  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model state
  bit   seqq[$];
  int   bpos = 0;
  int   pidx = 0;
  int   exp_err = 0;
  logic [31:0] mask = '0;

  function automatic bit seq_pop();
    bit b = seqq[0];
    seqq.push_back(seqq[0] ^ seqq[1]);  // b[n+15] = b[n] ^ b[n+1]
    void'(seqq.pop_front());
    return b;
  endfunction

  task automatic expect_reg(input logic a, input logic [31:0] e, input string tag);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 1'b0) mask = d;
    else           exp_err = 0;
  endtask

  // mode 0: sequence data, mode 1: all ones in enabled slots
  task automatic send_bits(input int nbits, input int mode, input int flip_every,
                           input bit force_fp);
    for (int i = 0; i < nbits; i++) begin
      bit fp, b, en;
      fp = (bpos == 0) || (i == 0 && force_fp);
      if (fp) bpos = 0;
      en = mask[bpos / 8];
      if (!en) begin
        b = ((i % 3) == 0);
      end else if (mode == 1) begin
        b = 1'b1;
      end else begin
        b = seq_pop();
        if (pidx >= 30 && flip_every > 0 && (pidx % flip_every) == 0) begin
          b = ~b;
          if (exp_err < 65535) exp_err++;
        end
        pidx++;
      end
      @(negedge clk);
      bit_en = 1'b1; frame_pulse = fp; rx_bit = b;
      bpos = (bpos + 1) % 256;
    end
    @(negedge clk);
    bit_en = 1'b0; frame_pulse = 1'b0;
  endtask

  // monitor: pops expectations and compares against register reads
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        sb_item_t it;
        it = sb[0];
        reg_raddr = it.addr;
        #1;
        total++;
        if (reg_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%0d expected=%0d", it.tag, reg_rdata, it.exp);
        end
        void'(sb.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 15; k++) seqq.push_back((k % 4) == 1 || k == 14);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(1'b0, 32'h0, "R1 enable after reset");
    expect_reg(1'b1, 32'h0, "R1 counter after reset");

    reg_write(1'b0, 32'h4000_0024);  // slots 2, 5, 30
    expect_reg(1'b0, 32'h4000_0024, "R2 enable readback");

    send_bits(1024, 1, 0, 1'b0);      // garbage: never locks
    expect_reg(1'b1, 32'h0, "R7 no count before lock");

    send_bits(768, 0, 0, 1'b0);       // clean sequence, junk in disabled slots
    expect_reg(1'b1, 32'h0, "R3 R4 clean chained sequence");

    send_bits(1024, 0, 7, 1'b0);
    expect_reg(1'b1, exp_err, "R5 R6 errors counted exactly");

    reg_write(1'b1, 32'hDEAD_BEEF);
    expect_reg(1'b1, 32'h0, "R9 clear by write");
    expect_reg(1'b0, 32'h4000_0024, "R9 enables kept");

    send_bits(100, 0, 0, 1'b0);       // partial frame
    send_bits(768, 0, 5, 1'b1);       // early frame pulse restarts position
    expect_reg(1'b1, exp_err, "R10 early frame pulse");

    reg_write(1'b0, 32'hFFFF_FFFF);
    expect_reg(1'b0, 32'hFFFF_FFFF, "R2 all slots enabled");
    send_bits(256 * 260, 0, 1, 1'b0);
    expect_reg(1'b1, 32'd65535, "R8 saturation");

    reg_write(1'b1, 32'h0);
    expect_reg(1'b1, 32'h0, "R9 clear from ceiling");
    send_bits(256, 0, 1, 1'b0);
    expect_reg(1'b1, 32'd256, "R8 R5 count resumes after clear");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule